// File: doc/BRIEF.md
# Product-Parity Single-Fix Decoder

This block receives a codeword laid out as a grid of ROWS+1 by COLS+1 bits. The top-left ROWS by COLS part holds the payload. Each payload row ends with an even-parity bit for that row. The bottom row holds an even-parity bit for each payload column. The bottom-right corner bit makes the parity of its row and of its column even. The decoder forms one parity check for each grid row and one for each grid column.

A bit of the grid is flipped back when both its row check and its column check fail. This repairs any single upset, whether it sits in the payload, a parity bit or the corner bit. When either check vector shows two or more failures, the block raises a retransmit request. A link controller can then ask for the word again. The repaired codeword, the repaired payload and both check vectors are registered, and they appear one clock after the word is presented.

Top module: `pp_decoder`

## Requirements
- R1: Grid cell (i, j) is bit i*(COLS+1)+j of `code_in` and `code_out`. Payload bits sit at i<ROWS and j<COLS. Row parity of row i sits at j=COLS. Column parity of column j sits at i=ROWS. The corner bit sits at (ROWS, COLS), which is the top bit.
- R2: `row_syn[i]` is the XOR of all COLS+1 bits of grid row i, for i from 0 to ROWS. The top bit covers the column parities and the corner bit.
- R3: `col_syn[j]` is the XOR of all ROWS+1 bits of grid column j, for j from 0 to COLS. The top bit covers the row parities and the corner bit.
- R4: Every output is registered. It shows the result for the `code_in` value sampled at the previous rising edge of `clk`. While synchronous `rst` is high, all outputs are cleared to zero.
- R5: A codeword with consistent parity is passed through unchanged, with both check vectors zero and `nack` low.
- R6: A single flipped bit anywhere in the grid, including a parity bit or the corner bit, is restored, and `nack` stays low.
- R7: The output bit at cell (i, j) differs from the input bit exactly when `row_syn[i]` and `col_syn[j]` are both 1.
- R8: `nack` is 1 exactly when `row_syn` or `col_syn` contains two or more ones.
- R9: Flips at (i,j), (i,k) and (l,j) with i≠l and j≠k leave both vectors one-hot at l and k. In that case `nack` stays low and cell (l,k) is also flipped.
- R10: `data_out` bit i*COLS+j carries the repaired payload cell (i, j).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_in | input | (ROWS+1)*(COLS+1) | Received codeword grid |
| code_out | output | (ROWS+1)*(COLS+1) | Repaired codeword grid |
| data_out | output | ROWS*COLS | Repaired payload bits |
| row_syn | output | ROWS+1 | Row check vector |
| col_syn | output | COLS+1 | Column check vector |
| nack | output | 1 | Two or more failures seen in a check vector |

## Verification
Clean words with several payload patterns show that nothing is altered when the parity holds. The single-flip sweep visits every cell, payload and parity alike. It tells apart the four kinds of position: payload, row parity, column parity and corner. Paired flips in a shared row, a shared column, or neither hit each vector's multi-failure detection separately. Three-flip patterns separate the corner-shaped case, which is silently miscorrected at the fourth cell, from a scattered case that must be flagged.

// File: rtl/pp_pkg.sv
package pp_pkg;
  // linear position of grid cell (r, c) in a grid with cols+1 columns
  function automatic int cell_pos(int r, int c, int cols);
    return r * (cols + 1) + c;
  endfunction
endpackage

// File: rtl/pp_syndrome.sv
module pp_syndrome #(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic [(ROWS+1)*(COLS+1)-1:0] cw,
  output logic [ROWS:0]                rs,
  output logic [COLS:0]                cs
);
  import pp_pkg::*;

  // every grid row and column, parity line included, must XOR to zero
  always_comb begin
    rs = '0;
    cs = '0;
    for (int i = 0; i <= ROWS; i++) begin
      for (int j = 0; j <= COLS; j++) begin
        rs[i] = rs[i] ^ cw[cell_pos(i, j, COLS)];
        cs[j] = cs[j] ^ cw[cell_pos(i, j, COLS)];
      end
    end
  end
endmodule

// File: rtl/pp_multi_detect.sv
module pp_multi_detect #(
  parameter int W = 5
) (
  input  logic [W-1:0] vec,
  output logic         multi
);
  // neither zero nor one-hot: some set bit has a set bit below it
  always_comb begin
    logic seen;
    seen  = 1'b0;
    multi = 1'b0;
    for (int k = 0; k < W; k++) begin
      multi = multi | (vec[k] & seen);
      seen  = seen | vec[k];
    end
  end
endmodule

// File: rtl/pp_decoder.sv
module pp_decoder #(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [(ROWS+1)*(COLS+1)-1:0] code_in,
  output logic [(ROWS+1)*(COLS+1)-1:0] code_out,
  output logic [ROWS*COLS-1:0]         data_out,
  output logic [ROWS:0]                row_syn,
  output logic [COLS:0]                col_syn,
  output logic                         nack
);
  import pp_pkg::*;

  localparam int CW = (ROWS + 1) * (COLS + 1);
  localparam int DW = ROWS * COLS;

  logic [ROWS:0] rs;
  logic [COLS:0] cs;
  logic          row_multi, col_multi;
  logic [CW-1:0] fix_mask;
  logic [CW-1:0] fixed;
  logic [DW-1:0] fixed_data;

  pp_syndrome #(.ROWS(ROWS), .COLS(COLS)) u_syn (
    .cw (code_in),
    .rs (rs),
    .cs (cs)
  );

  pp_multi_detect #(.W(ROWS + 1)) u_row_multi (
    .vec   (rs),
    .multi (row_multi)
  );

  pp_multi_detect #(.W(COLS + 1)) u_col_multi (
    .vec   (cs),
    .multi (col_multi)
  );

  // cross of failing row and failing column marks the cell to flip
  for (genvar i = 0; i <= ROWS; i++) begin : g_mrow
    for (genvar j = 0; j <= COLS; j++) begin : g_mcol
      assign fix_mask[cell_pos(i, j, COLS)] = rs[i] & cs[j];
    end
  end

  assign fixed = code_in ^ fix_mask;

  for (genvar i = 0; i < ROWS; i++) begin : g_drow
    for (genvar j = 0; j < COLS; j++) begin : g_dcol
      assign fixed_data[i*COLS + j] = fixed[cell_pos(i, j, COLS)];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_out <= '0;
      data_out <= '0;
      row_syn  <= '0;
      col_syn  <= '0;
      nack     <= 1'b0;
    end else begin
      code_out <= fixed;
      data_out <= fixed_data;
      row_syn  <= rs;
      col_syn  <= cs;
      nack     <= row_multi | col_multi;
    end
  end

  // checks on the registered results against the word that produced them
  logic loaded;
  always_ff @(posedge clk) begin
    if (rst) loaded <= 1'b0;
    else     loaded <= 1'b1;
  end

  assert_nack_matches_count_R8: assert property (@(posedge clk) disable iff (rst)
    nack == (($countones(row_syn) >= 2) || ($countones(col_syn) >= 2)));

  assert_clean_passthrough_R5: assert property (@(posedge clk) disable iff (rst)
    (loaded && row_syn == '0 && col_syn == '0) |-> (code_out == $past(code_in)));

  assert_one_fix_without_nack_R6: assert property (@(posedge clk) disable iff (rst)
    (loaded && !nack) |-> ($countones(code_out ^ $past(code_in)) <= 1));

  for (genvar i = 0; i <= ROWS; i++) begin : g_arow
    for (genvar j = 0; j <= COLS; j++) begin : g_acol
      assert_fix_only_at_cross_R7: assert property (@(posedge clk) disable iff (rst)
        (loaded && (code_out[cell_pos(i, j, COLS)] != $past(code_in[cell_pos(i, j, COLS)])))
          |-> (row_syn[i] && col_syn[j]));
    end
  end
endmodule

// File: tb/sim_pp_decoder.sv
`timescale 1ns/1ps
module sim_pp_decoder;
  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int CW = (ROWS + 1) * (COLS + 1);
  localparam int DW = ROWS * COLS;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] code_in = '0;
  logic [CW-1:0] code_out;
  logic [DW-1:0] data_out;
  logic [ROWS:0] row_syn;
  logic [COLS:0] col_syn;
  logic          nack;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pp_decoder #(.ROWS(ROWS), .COLS(COLS)) u0 (
    .clk(clk), .rst(rst), .code_in(code_in), .code_out(code_out),
    .data_out(data_out), .row_syn(row_syn), .col_syn(col_syn), .nack(nack)
  );

  function automatic int pos(int r, int c);
    return r * (COLS + 1) + c;
  endfunction

  // build a consistent grid from payload (R1 layout)
  function automatic logic [CW-1:0] encode(logic [DW-1:0] d);
    logic [CW-1:0] w;
    w = '0;
    for (int i = 0; i < ROWS; i++)
      for (int j = 0; j < COLS; j++) begin
        w[pos(i, j)]       = d[i*COLS + j];
        w[pos(i, COLS)]    = w[pos(i, COLS)] ^ d[i*COLS + j];
        w[pos(ROWS, j)]    = w[pos(ROWS, j)] ^ d[i*COLS + j];
        w[pos(ROWS, COLS)] = w[pos(ROWS, COLS)] ^ d[i*COLS + j];
      end
    return w;
  endfunction

  function automatic logic [DW-1:0] payload(logic [CW-1:0] w);
    logic [DW-1:0] d;
    for (int i = 0; i < ROWS; i++)
      for (int j = 0; j < COLS; j++) d[i*COLS + j] = w[pos(i, j)];
    return d;
  endfunction

  // expected check vectors from the set of flipped cells
  function automatic logic [ROWS:0] rows_hit(logic [CW-1:0] f);
    logic [ROWS:0] v = '0;
    for (int i = 0; i <= ROWS; i++)
      for (int j = 0; j <= COLS; j++) v[i] = v[i] ^ f[pos(i, j)];
    return v;
  endfunction

  function automatic logic [COLS:0] cols_hit(logic [CW-1:0] f);
    logic [COLS:0] v = '0;
    for (int i = 0; i <= ROWS; i++)
      for (int j = 0; j <= COLS; j++) v[j] = v[j] ^ f[pos(i, j)];
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [CW-1:0] w);
    @(negedge clk);
    code_in = w;
    @(posedge clk);
    @(negedge clk);
  endtask

  // present word, then check everything against expectations
  task automatic run_case(input logic [CW-1:0] good, input logic [CW-1:0] flips,
                          input logic [CW-1:0] exp_code, input bit exp_nack, input string req);
    logic [ROWS:0] er;
    logic [COLS:0] ec;
    er = rows_hit(flips);
    ec = cols_hit(flips);
    apply(good ^ flips);
    chk(row_syn == er, {req, " R2 row_syn"}, 64'(row_syn), 64'(er));
    chk(col_syn == ec, {req, " R3 col_syn"}, 64'(col_syn), 64'(ec));
    chk(nack == exp_nack, {req, " R8 nack"}, 64'(nack), 64'(exp_nack));
    if (!exp_nack) begin
      chk(code_out == exp_code, {req, " R7 code_out"}, 64'(code_out), 64'(exp_code));
      chk(data_out == payload(exp_code), {req, " R10 data_out"}, 64'(data_out), 64'(payload(exp_code)));
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    code_in = encode(16'hBEEF) ^ 25'h1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(code_out == '0 && data_out == '0, "R4 reset data", 64'(code_out), 64'd0);
    chk(row_syn == '0 && col_syn == '0 && !nack, "R4 reset flags", 64'({row_syn, col_syn, nack}), 64'd0);
    rst = 1'b0;
  endtask

  task automatic t_clean();
    logic [DW-1:0] pats [3] = '{16'h0000, 16'hFFFF, 16'hA5C3};
    foreach (pats[p]) run_case(encode(pats[p]), '0, encode(pats[p]), 1'b0, "R5 clean");
  endtask

  task automatic t_latency();
    // R4: output follows the word of the previous edge, not the one after it
    @(negedge clk); code_in = encode(16'h1234);
    @(posedge clk);
    @(negedge clk); code_in = encode(16'h4321);
    chk(data_out == 16'h1234, "R4 one-cycle latency", 64'(data_out), 64'h1234);
  endtask

  task automatic t_single();
    logic [CW-1:0] g;
    g = encode(16'h3C69);
    for (int p = 0; p < CW; p++)
      run_case(g, CW'(1) << p, g, 1'b0, (p == CW-1) ? "R6 R1 corner flip" : "R6 single flip");
  endtask

  task automatic t_double();
    logic [CW-1:0] g;
    g = encode(16'h5A0F);
    run_case(g, (CW'(1) << pos(0, 0)) | (CW'(1) << pos(2, 3)), g, 1'b1, "R8 diag pair");
    run_case(g, (CW'(1) << pos(1, 0)) | (CW'(1) << pos(1, 2)), g, 1'b1, "R8 same row");
    run_case(g, (CW'(1) << pos(0, 3)) | (CW'(1) << pos(3, 3)), g, 1'b1, "R8 same column");
    run_case(g, (CW'(1) << pos(2, COLS)) | (CW'(1) << pos(ROWS, 1)), g, 1'b1, "R8 parity pair");
  endtask

  task automatic t_triple();
    logic [CW-1:0] g, f;
    g = encode(16'hC0DE);
    f = (CW'(1) << pos(1, 1)) | (CW'(1) << pos(1, 3)) | (CW'(1) << pos(3, 1));
    run_case(g, f, g ^ f ^ (CW'(1) << pos(3, 3)), 1'b0, "R9 corner triple");
    f = (CW'(1) << pos(0, 0)) | (CW'(1) << pos(0, COLS)) | (CW'(1) << pos(2, 0));
    run_case(g, f, g ^ f ^ (CW'(1) << pos(2, COLS)), 1'b0, "R9 triple onto row parity");
    f = (CW'(1) << pos(1, 1)) | (CW'(1) << pos(2, 3)) | (CW'(1) << pos(0, 2));
    run_case(g, f, g, 1'b1, "R8 scattered triple");
  endtask

  initial begin
    t_reset();
    t_clean();
    t_latency();
    t_single();
    t_double();
    t_triple();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule